// File: doc/BRIEF.md
# Two-Stage Sensor Sample Clock Divider

This block turns a fast source clock into the sample-enable strobe for a temperature converter. The source clock first passes through a fixed power-of-two prescaler, 1024 by default. A programmable stage then divides the prescaler output further. The programmable ratio is held as a compact 6-bit code, and each code step is worth 32 prescaler ticks. Code 0 skips the programmable stage, so that only the prescale applies.

The result is a strobe that is high for exactly one source cycle, once per full divided period. A new code can be written at any time. It is held as pending and only becomes active at the next terminal count of the divider, so the period in progress is never cut short. Decoding of the surrounding register is left to the caller, which presents only the code field and a write pulse.

Top module: `adc_tick_divider`

## Requirements
- R1: While reset is applied, `sample_stb_o` is low. After reset the pending and active codes both equal `RESET_CODE`, which defaults to 32. The first strobe is high in the cycle after the edge numbered `2**PRESCALE_LOG2 * RESET_CODE * 2**STEP_LOG2`, where the edge numbering starts at 1 with the first rising edge on which reset is released.
- R2: Every strobe lasts exactly one source cycle.
- R3: For an active code c in the range 1 to 2**FIELD_W-1, consecutive strobes are `2**PRESCALE_LOG2 * c * 2**STEP_LOG2` cycles apart. With the default parameters that is 1024 × (32 to 2016).
- R4: An active code of 0 bypasses the programmable stage, and strobes are then `2**PRESCALE_LOG2` cycles apart.
- R5: A code written while a period is in progress does not change that period. It sets the length of the period that starts at the next strobe.
- R6: A code written on the same clock edge as a terminal count is not taken for the period starting at that edge. It governs the period after that one.
- R7: When several codes are written within one period, only the last one written takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast source clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| ratio_wr_i | input | 1 | One-cycle write pulse for the ratio code |
| ratio_code_i | input | FIELD_W | Ratio code: 0 selects bypass, and c > 0 divides by c × 2**STEP_LOG2 |
| sample_stb_o | output | 1 | Sample strobe, high for one source cycle per period |

## Verification
The checker takes for granted that reset is held across at least one rising edge and that the prescale width is at least one bit. Under that assumption the strobe can never be high on two consecutive cycles. The checker does not follow the written codes. It only assumes that every code is a legal value of the field, which makes every interval a multiple of the prescale and no longer than the period of the largest code. The bench keeps to these limits: it drives codes only from the field range, applies reset for several cycles, and uses small prescale and step widths so that the longest period stays short. Its writes fall at random offsets and at the exact terminal edge.

// File: rtl/adc_div_pkg.sv
package adc_div_pkg;
   typedef enum logic {
      MODE_BYPASS = 1'b0,
      MODE_DIVIDE = 1'b1
   } div_mode_e;
endpackage

// File: rtl/adc_div_prescaler.sv
module adc_div_prescaler #(
   parameter int PRESCALE_LOG2 = 10
) (
   input  logic clk_i,
   input  logic rst_ni,
   output logic tick_o
);
   logic [PRESCALE_LOG2-1:0] pre_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) pre_q <= '0;
      else         pre_q <= pre_q + 1'b1;
   end

   // terminal value of the free-running counter marks one prescaled tick
   assign tick_o = &pre_q;
endmodule

// File: rtl/adc_div_ratio_reg.sv
module adc_div_ratio_reg
   import adc_div_pkg::*;
#(
   parameter int               FIELD_W    = 6,
   parameter logic [FIELD_W-1:0] RESET_CODE = FIELD_W'(32)
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               wr_i,
   input  logic [FIELD_W-1:0] code_i,
   input  logic               load_i,
   output logic [FIELD_W-1:0] act_code_o,
   output div_mode_e          mode_o
);
   logic [FIELD_W-1:0] pend_q;
   logic [FIELD_W-1:0] act_q;

   // pending copy follows every write; last write wins
   always_ff @(posedge clk_i) begin
      if (!rst_ni)   pend_q <= RESET_CODE;
      else if (wr_i) pend_q <= code_i;
   end

   // active copy only moves at a terminal count, so a period is never cut
   always_ff @(posedge clk_i) begin
      if (!rst_ni)     act_q <= RESET_CODE;
      else if (load_i) act_q <= pend_q;
   end

   assign act_code_o = act_q;
   assign mode_o     = (act_q == '0) ? MODE_BYPASS : MODE_DIVIDE;
endmodule

// File: rtl/adc_div_prog_counter.sv
module adc_div_prog_counter
   import adc_div_pkg::*;
#(
   parameter int FIELD_W   = 6,
   parameter int STEP_LOG2 = 5
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               tick_i,
   input  logic [FIELD_W-1:0] act_code_i,
   input  div_mode_e          mode_i,
   output logic               term_o
);
   localparam int CNT_W = FIELD_W + STEP_LOG2;

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] limit;
   logic             at_limit;

   generate
      if (STEP_LOG2 == 0) begin : g_unit_step
         assign limit = act_code_i - 1'b1;
      end else begin : g_scaled_step
         assign limit = {act_code_i, {STEP_LOG2{1'b0}}} - 1'b1;
      end
   endgenerate

   assign at_limit = (mode_i == MODE_BYPASS) || (cnt_q == limit);
   assign term_o   = tick_i && at_limit;

   always_ff @(posedge clk_i) begin
      if (!rst_ni)     cnt_q <= '0;
      else if (term_o) cnt_q <= '0;
      else if (tick_i) cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/adc_tick_divider.sv
module adc_tick_divider
   import adc_div_pkg::*;
#(
   parameter int                 PRESCALE_LOG2 = 10,
   parameter int                 STEP_LOG2     = 5,
   parameter int                 FIELD_W       = 6,
   parameter logic [FIELD_W-1:0] RESET_CODE    = FIELD_W'(32)
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               ratio_wr_i,
   input  logic [FIELD_W-1:0] ratio_code_i,
   output logic               sample_stb_o
);
   generate
      if (PRESCALE_LOG2 < 1) begin : g_bad_prescale
         $error("PRESCALE_LOG2 must be at least 1");
      end
      if (FIELD_W < 1) begin : g_bad_field
         $error("FIELD_W must be at least 1");
      end
      if (STEP_LOG2 < 0) begin : g_bad_step
         $error("STEP_LOG2 must not be negative");
      end
   endgenerate

   logic               pre_tick;
   logic               term;
   logic [FIELD_W-1:0] act_code;
   div_mode_e          mode;
   logic               stb_q;

   adc_div_prescaler #(
      .PRESCALE_LOG2(PRESCALE_LOG2)
   ) i_prescaler (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .tick_o(pre_tick)
   );

   adc_div_ratio_reg #(
      .FIELD_W   (FIELD_W),
      .RESET_CODE(RESET_CODE)
   ) i_ratio_reg (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_i      (ratio_wr_i),
      .code_i    (ratio_code_i),
      .load_i    (term),
      .act_code_o(act_code),
      .mode_o    (mode)
   );

   adc_div_prog_counter #(
      .FIELD_W  (FIELD_W),
      .STEP_LOG2(STEP_LOG2)
   ) i_prog_counter (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .tick_i    (pre_tick),
      .act_code_i(act_code),
      .mode_i    (mode),
      .term_o    (term)
   );

   always_ff @(posedge clk_i) begin
      if (!rst_ni) stb_q <= 1'b0;
      else         stb_q <= term;
   end

   assign sample_stb_o = stb_q;
endmodule

// File: rtl/adc_tick_divider_chk.sv
module adc_tick_divider_chk #(
   parameter int                 PRESCALE_LOG2 = 10,
   parameter int                 STEP_LOG2     = 5,
   parameter int                 FIELD_W       = 6,
   parameter logic [FIELD_W-1:0] RESET_CODE    = FIELD_W'(32)
) (
   input logic               clk_i,
   input logic               rst_ni,
   input logic               ratio_wr_i,
   input logic [FIELD_W-1:0] ratio_code_i,
   input logic               sample_stb_o
);
   localparam logic [31:0] PRE        = 32'(1) << PRESCALE_LOG2;
   localparam logic [31:0] STEP       = 32'(1) << STEP_LOG2;
   localparam logic [31:0] MAX_CODE   = (32'(1) << FIELD_W) - 32'(1);
   localparam logic [31:0] FIRST_GAP  = PRE * 32'(RESET_CODE) * STEP;
   localparam logic [31:0] MAX_GAP    = PRE * MAX_CODE * STEP;

   logic [31:0] gap_q;
   logic        seen_q;

   // cycles since reset or since the last strobe
   always_ff @(posedge clk_i) begin
      if (!rst_ni)           gap_q <= '0;
      else if (sample_stb_o) gap_q <= 32'd1;
      else                   gap_q <= gap_q + 32'd1;
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni)           seen_q <= 1'b0;
      else if (sample_stb_o) seen_q <= 1'b1;
   end

   AST_SINGLE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sample_stb_o |=> !sample_stb_o); // R2
   AST_FIRST_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sample_stb_o && !seen_q) |-> (gap_q == FIRST_GAP)); // R1
   AST_PRESCALE_MULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sample_stb_o |-> (gap_q[PRESCALE_LOG2-1:0] == '0)); // R3
   AST_MIN_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sample_stb_o |-> (gap_q >= PRE)); // R4
   AST_MAX_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      gap_q <= MAX_GAP); // R3
   AST_WRITE_NO_GLITCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ratio_wr_i && !sample_stb_o && (ratio_code_i != '0)) |=> !sample_stb_o || seen_q || (gap_q == FIRST_GAP)); // R5
endmodule

bind adc_tick_divider adc_tick_divider_chk #(
   .PRESCALE_LOG2(PRESCALE_LOG2),
   .STEP_LOG2    (STEP_LOG2),
   .FIELD_W      (FIELD_W),
   .RESET_CODE   (RESET_CODE)
) i_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .ratio_wr_i  (ratio_wr_i),
   .ratio_code_i(ratio_code_i),
   .sample_stb_o(sample_stb_o)
);

// File: tb/test_adc_tick_divider.sv
module test_adc_tick_divider;
   localparam int CLK_PERIOD = 10;
   localparam int PL   = 2;
   localparam int SL   = 1;
   localparam int FW   = 6;
   localparam int RC   = 32;
   localparam int PRE  = 1 << PL;
   localparam int STEP = 1 << SL;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr = 1'b0;
   logic [FW-1:0] code = '0;
   logic          stb;

   int    checks = 0;
   int    errors = 0;
   int    edge_n = 0;
   int    next_exp = 0;
   int    pend = RC;
   string tag = "R1";
   bit    done = 1'b0;

   adc_tick_divider #(
      .PRESCALE_LOG2(PL),
      .STEP_LOG2    (SL),
      .FIELD_W      (FW),
      .RESET_CODE   (FW'(RC))
   ) i_adc_tick_divider (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .ratio_wr_i  (wr),
      .ratio_code_i(code),
      .sample_stb_o(stb)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic int period_of(int c);
      return (c == 0) ? PRE : PRE * c * STEP;
   endfunction

   task automatic check(bit ok, string what, int act, int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s at edge %0d: actual %0d expected %0d",
                  tag, what, edge_n, act, expv);
      end
   endtask

   // one source cycle: inputs set at the falling edge, strobe sampled at the next
   task automatic cyc(bit w, logic [FW-1:0] d);
      bit exp_s;
      wr   = w;
      code = d;
      @(posedge clk);
      edge_n++;
      exp_s = (edge_n == next_exp);
      if (exp_s) next_exp = edge_n + period_of(pend);
      if (w) pend = int'(d);
      @(negedge clk);
      wr = 1'b0;
      check(stb == exp_s, "strobe", int'(stb), int'(exp_s));
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) cyc(1'b0, '0);
   endtask

   task automatic to_terminal();
      while (edge_n + 1 != next_exp) cyc(1'b0, '0);
   endtask

   task automatic do_reset();
      tag = "R1";
      rst_n = 1'b0;
      wr = 1'b0;
      repeat (3) @(negedge clk);
      check(stb == 1'b0, "strobe in reset", int'(stb), 0);
      rst_n = 1'b1;
      edge_n = 0;
      pend = RC;
      next_exp = period_of(RC);
   endtask

   initial begin
      int seed;
      seed = $urandom(32'd1234);
      @(negedge clk);
      // R1: reset state and first full period
      do_reset();
      idle(period_of(RC) * 2 + 5);
      // R3: smallest and largest codes
      tag = "R3";
      cyc(1'b1, FW'(1));
      idle(period_of(RC) + period_of(1) * 3);
      cyc(1'b1, FW'(63));
      idle(period_of(1) + period_of(63) * 2 + 3);
      // R4: bypass code
      tag = "R4";
      cyc(1'b1, FW'(0));
      idle(period_of(63) + PRE * 6);
      // R6: write exactly on the terminal edge
      tag = "R6";
      cyc(1'b1, FW'(3));
      to_terminal();
      cyc(1'b1, FW'(5));
      idle(period_of(3) * 2 + period_of(5) * 2);
      to_terminal();
      cyc(1'b1, FW'(0));
      idle(period_of(5) + PRE * 4);
      // R5: write in the middle of a long period
      tag = "R5";
      cyc(1'b1, FW'(40));
      to_terminal();
      idle(period_of(40) / 2);
      cyc(1'b1, FW'(2));
      idle(period_of(40) + period_of(2) * 3);
      // R7: several writes inside one period
      tag = "R7";
      cyc(1'b1, FW'(9));
      cyc(1'b1, FW'(17));
      cyc(1'b1, FW'(4));
      idle(period_of(2) + period_of(4) * 3);
      // R2: random codes at random offsets
      tag = "R2";
      for (int k = 0; k < 40; k++) begin
         cyc(1'b1, FW'($urandom_range(0, 63)));
         idle(int'($urandom_range(1, 300)));
      end
      idle(period_of(63) * 2);
      // R1: reset again in the middle of a period
      idle(37);
      do_reset();
      idle(period_of(RC) + 10);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual running expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule